// File: doc/BRIEF.md
# Per-Channel Idle Code Inserter

This block overwrites selected timeslots of a serial TDM transmit stream with a fixed byte held per channel. A byte-wide host port reaches a 64-entry code store indirectly. The host first writes a slot pointer register and then reads or writes a code data register. The lower 32 entries serve the transmit direction. The upper 32 entries form a receive bank that the host can write and read, but that nothing in this block consumes. Two flag bits in the pointer register turn a data write into a fill of a whole bank. Four slot enable registers, one bit per channel, choose which transmit timeslots are replaced.

On the line side, a single system clock runs the block. A bit strobe marks each serial bit, and a frame-sync pulse arrives together with the strobe of a frame's first bit. In 32-channel mode a frame is 256 bits. In 24-channel mode a frame is one framing bit followed by 192 channel bits. The framing bit is never touched. For each channel whose enable bit is set, the stored code is sent most significant bit first in place of the incoming bits. All other bits pass through unchanged.

Top module: `chan_fill_ins`

## Requirements
- R1: After reset, every host register (pointer 7Eh, data 7Fh, enables 80h–83h) reads 00h, every code entry is 00h, and tx_out is 0.
- R2: The pointer register at 7Eh holds the entry pointer in bits 5..0, a transmit-fill flag in bit 6 and a receive-fill flag in bit 7. It reads back as written and is not changed by data register accesses (no auto-increment).
- R3: While both fill flags are 0, a write to 7Fh stores the byte only in the entry at the pointer, and a read of 7Fh returns that entry. Pointer values 00h–1Fh select the transmit codes for channels 1–32 (entry = channel − 1), and values 20h–3Fh select the receive codes.
- R4: While either fill flag is 1, a read of 7Fh returns 00h.
- R5: With the transmit-fill flag set, a write to 7Fh loads the byte into all 32 transmit entries and leaves the receive entries unchanged.
- R6: With the receive-fill flag set, a write to 7Fh loads the byte into all 32 receive entries and leaves the transmit entries unchanged.
- R7: The enable registers 80h, 81h, 82h and 83h read back as written, with bit 0 of 80h for channel 1 up to bit 7 of 83h for channel 32. Other addresses read 00h, and writes to them change nothing.
- R8: In 32-channel mode (mode_e1 = 1), frame bit 8(k−1)+j (j = 0..7) belongs to channel k. If that channel is enabled, its output is bit 7−j of the channel's transmit code. Otherwise the input bit passes through.
- R9: In 24-channel mode (mode_e1 = 0), frame bit 0 is the framing bit and always passes through. Channel k occupies bits 1+8(k−1) to 8+8(k−1). Enable bits and codes of channels 25–32 have no effect.
- R10: tx_out changes only on a clock edge where bit_en = 1. It then shows the result for the bit presented with that strobe and holds it until the next strobe.
- R11: A frame_sync seen with bit_en marks bit 0 of a frame, even in the middle of a frame. Without frame_sync, the bit count wraps after 256 bits (32-channel mode) or 193 bits (24-channel mode).
- R12: A channel's enable bit and code are sampled at the first bit of its timeslot. Host writes later in that slot take effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_e1 | input | 1 | 1: 32-channel frame of 256 bits, 0: 24-channel frame with framing bit |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_rdata | output | 8 | Host read data for host_addr (combinational) |
| bit_en | input | 1 | Serial bit strobe, one clock per line bit |
| frame_sync | input | 1 | First-bit-of-frame marker, valid with bit_en |
| tx_in | input | 1 | Incoming serial transmit data |
| tx_out | output | 1 | Serial data after slot substitution |

## Verification
The hardest case to reach from the ports is a host write that lands inside a timeslot that is already being replaced. It needs a pointer write and a data write placed between two strobes of the same slot. The bench's line driver issues both writes just after the fourth bit of an enabled channel. Its scoreboard expects the old code for the rest of that slot and the new code in the following frame. A partial frame cut short by frame_sync and a frame sent with no frame_sync test the restart and the wrap of the bit count. Changing mode between frames shows that enables of channels 25–32 have no effect in 24-channel mode.

// File: rtl/chan_fill_pkg.sv
package chan_fill_pkg;

   // Host register decode result
   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_PTR,
      SEL_DATA,
      SEL_EN
   } reg_sel_e;

endpackage

// File: rtl/chan_fill_regs.sv
module chan_fill_regs
   import chan_fill_pkg::*;
#(
   parameter int unsigned CODE_W    = 8,
   parameter int unsigned CH_MAX    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PTR_ADDR  = 'h7E,
   parameter int unsigned DATA_ADDR = 'h7F,
   parameter int unsigned EN_BASE   = 'h80
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        host_addr,
   input  logic [CODE_W-1:0]        host_wdata,
   input  logic                     host_we,
   output logic [CODE_W-1:0]        host_rdata,
   output logic [CH_MAX*CODE_W-1:0] tx_codes,
   output logic [CH_MAX-1:0]        tx_en
);

   localparam int unsigned ENTRIES  = 2 * CH_MAX;
   localparam int unsigned PTR_W    = $clog2(ENTRIES);
   localparam int unsigned PW       = PTR_W + 2;
   localparam int unsigned EN_REGS  = CH_MAX / CODE_W;
   localparam int unsigned EN_IDX_W = (EN_REGS > 1) ? $clog2(EN_REGS) : 1;
   localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(PTR_ADDR);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
   localparam logic [ADDR_W-1:0] A_ENLO = ADDR_W'(EN_BASE);
   localparam logic [ADDR_W-1:0] A_ENHI = ADDR_W'(EN_BASE + EN_REGS - 1);

   if (CH_MAX % CODE_W != 0) begin : g_bad_en
      $error("CH_MAX must be a multiple of CODE_W");
   end
   if (CODE_W < PW) begin : g_bad_ptr
      $error("CODE_W too narrow for pointer and fill flags");
   end

   logic [PW-1:0]     ptr_word_q;
   logic [PTR_W-1:0]  ptr_q;
   logic              fill_tx, fill_rx;
   logic [CODE_W-1:0] mem_q [ENTRIES];
   logic [CODE_W-1:0] en_q  [EN_REGS];
   reg_sel_e          sel;
   logic [EN_IDX_W-1:0] en_idx;
   logic              ptr_wr, data_wr, en_wr;
   logic [ENTRIES-1:0] ent_hit;

   assign ptr_q   = ptr_word_q[PTR_W-1:0];
   assign fill_tx = ptr_word_q[PTR_W];
   assign fill_rx = ptr_word_q[PTR_W+1];

   always_comb begin
      sel    = SEL_NONE;
      en_idx = '0;
      if (host_addr == A_PTR) begin
         sel = SEL_PTR;
      end else if (host_addr == A_DATA) begin
         sel = SEL_DATA;
      end else if (host_addr >= A_ENLO && host_addr <= A_ENHI) begin
         sel    = SEL_EN;
         en_idx = EN_IDX_W'(host_addr - A_ENLO);
      end
   end

   assign ptr_wr  = host_we && (sel == SEL_PTR);
   assign data_wr = host_we && (sel == SEL_DATA);
   assign en_wr   = host_we && (sel == SEL_EN);

   // Per-entry write select: bank fill or single pointed entry
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      localparam bit IS_TX = (e < CH_MAX);
      logic bank_fill;
      assign bank_fill  = IS_TX ? fill_tx : fill_rx;
      assign ent_hit[e] = data_wr &&
                          (bank_fill || (!fill_tx && !fill_rx && ptr_q == PTR_W'(e)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_word_q <= '0;
         for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
         for (int r = 0; r < EN_REGS; r++) en_q[r] <= '0;
      end else begin
         if (ptr_wr) ptr_word_q <= host_wdata[PW-1:0];
         for (int i = 0; i < ENTRIES; i++) begin
            if (ent_hit[i]) mem_q[i] <= host_wdata;
         end
         for (int r = 0; r < EN_REGS; r++) begin
            if (en_wr && en_idx == EN_IDX_W'(r)) en_q[r] <= host_wdata;
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      unique case (sel)
         SEL_PTR:  host_rdata = CODE_W'(ptr_word_q);
         SEL_DATA: host_rdata = (fill_tx || fill_rx) ? '0 : mem_q[ptr_q];
         SEL_EN:   host_rdata = en_q[en_idx];
         default:  host_rdata = '0;
      endcase
   end

   for (genvar c = 0; c < CH_MAX; c++) begin : g_out
      assign tx_codes[c*CODE_W +: CODE_W] = mem_q[c];
      assign tx_en[c] = en_q[c / CODE_W][c % CODE_W];
   end

   // R5
   tx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && fill_tx) |=> (mem_q[0] == $past(host_wdata) &&
                                mem_q[CH_MAX-1] == $past(host_wdata)));

   // R6
   rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && fill_rx) |=> (mem_q[CH_MAX] == $past(host_wdata) &&
                                mem_q[ENTRIES-1] == $past(host_wdata)));

   // R2
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_wr |=> $stable(ptr_word_q));

endmodule

// File: rtl/chan_fill_slot.sv
module chan_fill_slot #(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned CH_MAX = 32,
   parameter int unsigned T1_CH  = 24
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode_e1,
   input  logic                       bit_en,
   input  logic                       frame_sync,
   output logic                       cur_fbit,
   output logic [$clog2(CH_MAX)-1:0]  cur_slot,
   output logic [$clog2(CODE_W)-1:0]  cur_bit
);

   localparam int unsigned SLOT_W = $clog2(CH_MAX);
   localparam int unsigned BIT_W  = $clog2(CODE_W);
   localparam int unsigned POS_W  = SLOT_W + BIT_W;
   localparam int unsigned E1_LEN = CH_MAX * CODE_W;
   localparam int unsigned T1_LEN = T1_CH * CODE_W + 1;
   localparam logic [POS_W-1:0] E1_LAST = POS_W'(E1_LEN - 1);
   localparam logic [POS_W-1:0] T1_LAST = POS_W'(T1_LEN - 1);

   if ((1 << BIT_W) != CODE_W) begin : g_bad_code
      $error("CODE_W must be a power of two");
   end
   if ((1 << SLOT_W) != CH_MAX) begin : g_bad_ch
      $error("CH_MAX must be a power of two");
   end
   if (T1_CH >= CH_MAX) begin : g_bad_t1
      $error("T1_CH must be below CH_MAX");
   end

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] cur_pos, last_pos, off;

   assign cur_pos  = frame_sync ? '0 : pos_q;
   assign last_pos = mode_e1 ? E1_LAST : T1_LAST;
   assign off      = mode_e1 ? cur_pos : cur_pos - POS_W'(1);
   assign cur_fbit = !mode_e1 && (cur_pos == '0);
   assign cur_slot = off[POS_W-1:BIT_W];
   assign cur_bit  = off[BIT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (bit_en) begin
         pos_q <= (cur_pos >= last_pos) ? '0 : cur_pos + POS_W'(1);
      end
   end

   // R11
   pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(pos_q));

endmodule

// File: rtl/chan_fill_sub.sv
module chan_fill_sub #(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned CH_MAX = 32,
   parameter int unsigned T1_CH  = 24
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode_e1,
   input  logic                       bit_en,
   input  logic                       tx_in,
   input  logic                       cur_fbit,
   input  logic [$clog2(CH_MAX)-1:0]  cur_slot,
   input  logic [$clog2(CODE_W)-1:0]  cur_bit,
   input  logic [CH_MAX*CODE_W-1:0]   tx_codes,
   input  logic [CH_MAX-1:0]          tx_en,
   output logic                       tx_out
);

   localparam int unsigned SLOT_W = $clog2(CH_MAX);
   localparam int unsigned BIT_W  = $clog2(CODE_W);
   localparam logic [BIT_W-1:0]  MSB_I   = BIT_W'(CODE_W - 1);
   localparam logic [SLOT_W-1:0] T1_SLOTS = SLOT_W'(T1_CH);

   logic [CODE_W-1:0] code_now, code_use, hold_code;
   logic              en_now, en_use, hold_en;
   logic              slot_start, code_bit, out_q;

   assign code_now   = tx_codes[cur_slot*CODE_W +: CODE_W];
   assign en_now     = tx_en[cur_slot] && (mode_e1 || cur_slot < T1_SLOTS);
   assign slot_start = !cur_fbit && (cur_bit == '0);

   always_comb begin
      if (slot_start) begin
         en_use   = en_now;
         code_use = code_now;
      end else begin
         en_use   = hold_en;
         code_use = hold_code;
      end
   end

   assign code_bit = code_use[MSB_I - cur_bit];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_en   <= 1'b0;
         hold_code <= '0;
         out_q     <= 1'b0;
      end else if (bit_en) begin
         if (slot_start) begin
            hold_en   <= en_now;
            hold_code <= code_now;
         end
         out_q <= (!cur_fbit && en_use) ? code_bit : tx_in;
      end
   end

   assign tx_out = out_q;

   // R9
   fbit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && cur_fbit) |=> (tx_out == $past(tx_in)));

   // R8
   off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !cur_fbit && cur_bit != '0 && !hold_en) |=> (tx_out == $past(tx_in)));

   // R12
   mid_slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !slot_start) |=> ($stable(hold_code) && $stable(hold_en)));

   // R10
   out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_out));

endmodule

// File: rtl/chan_fill_ins.sv
module chan_fill_ins #(
   parameter int unsigned CODE_W    = 8,
   parameter int unsigned CH_MAX    = 32,
   parameter int unsigned T1_CH     = 24,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PTR_ADDR  = 'h7E,
   parameter int unsigned DATA_ADDR = 'h7F,
   parameter int unsigned EN_BASE   = 'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_e1,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [CODE_W-1:0] host_wdata,
   input  logic              host_we,
   output logic [CODE_W-1:0] host_rdata,
   input  logic              bit_en,
   input  logic              frame_sync,
   input  logic              tx_in,
   output logic              tx_out
);

   localparam int unsigned SLOT_W = $clog2(CH_MAX);
   localparam int unsigned BIT_W  = $clog2(CODE_W);

   logic [CH_MAX*CODE_W-1:0] tx_codes;
   logic [CH_MAX-1:0]        tx_en;
   logic                     cur_fbit;
   logic [SLOT_W-1:0]        cur_slot;
   logic [BIT_W-1:0]         cur_bit;

   chan_fill_regs #(
      .CODE_W(CODE_W), .CH_MAX(CH_MAX), .ADDR_W(ADDR_W),
      .PTR_ADDR(PTR_ADDR), .DATA_ADDR(DATA_ADDR), .EN_BASE(EN_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we),
      .host_rdata(host_rdata), .tx_codes(tx_codes), .tx_en(tx_en)
   );

   chan_fill_slot #(
      .CODE_W(CODE_W), .CH_MAX(CH_MAX), .T1_CH(T1_CH)
   ) u_slot (
      .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1),
      .bit_en(bit_en), .frame_sync(frame_sync),
      .cur_fbit(cur_fbit), .cur_slot(cur_slot), .cur_bit(cur_bit)
   );

   chan_fill_sub #(
      .CODE_W(CODE_W), .CH_MAX(CH_MAX), .T1_CH(T1_CH)
   ) u_sub (
      .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1),
      .bit_en(bit_en), .tx_in(tx_in),
      .cur_fbit(cur_fbit), .cur_slot(cur_slot), .cur_bit(cur_bit),
      .tx_codes(tx_codes), .tx_en(tx_en), .tx_out(tx_out)
   );

endmodule

// File: tb/chan_fill_ins_tb.sv
module chan_fill_ins_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_e1 = 1'b1;
   logic [7:0] host_addr = 8'h00;
   logic [7:0] host_wdata = 8'h00;
   logic       host_we = 1'b0;
   logic [7:0] host_rdata;
   logic       bit_en = 1'b0;
   logic       frame_sync = 1'b0;
   logic       tx_in = 1'b0;
   logic       tx_out;

   always #4 clk = ~clk;

   chan_fill_ins u_dut (
      .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we),
      .host_rdata(host_rdata), .bit_en(bit_en), .frame_sync(frame_sync),
      .tx_in(tx_in), .tx_out(tx_out)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Requirement model of the host-visible state
   logic [5:0]  m_ptr = '0;
   logic        m_gtx = 1'b0, m_grx = 1'b0;
   logic [7:0]  m_tx [32];
   logic [7:0]  m_rx [32];
   logic [31:0] m_en = '0;

   // Scoreboard queues
   logic  exp_q [$];
   string tag_q [$];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_read(logic [7:0] a);
      case (a)
         8'h7E: return {m_grx, m_gtx, m_ptr};
         8'h7F: begin
            if (m_gtx || m_grx) return 8'h00;
            return m_ptr[5] ? m_rx[m_ptr[4:0]] : m_tx[m_ptr[4:0]];
         end
         8'h80: return m_en[7:0];
         8'h81: return m_en[15:8];
         8'h82: return m_en[23:16];
         8'h83: return m_en[31:24];
         default: return 8'h00;
      endcase
   endfunction

   task automatic hwr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
      case (a)
         8'h7E: {m_grx, m_gtx, m_ptr} = d;
         8'h7F: begin
            if (m_gtx) for (int i = 0; i < 32; i++) m_tx[i] = d;
            if (m_grx) for (int i = 0; i < 32; i++) m_rx[i] = d;
            if (!m_gtx && !m_grx) begin
               if (m_ptr[5]) m_rx[m_ptr[4:0]] = d;
               else          m_tx[m_ptr[4:0]] = d;
            end
         end
         8'h80: m_en[7:0]   = d;
         8'h81: m_en[15:8]  = d;
         8'h82: m_en[23:16] = d;
         8'h83: m_en[31:24] = d;
         default: ;
      endcase
   endtask

   task automatic hrd(logic [7:0] a, string tag);
      @(negedge clk);
      host_addr = a;
      #1;
      chk(tag, host_rdata, m_read(a));
   endtask

   task automatic rd_entry(logic [5:0] p, string tag);
      hwr(8'h7E, {2'b00, p});
      hrd(8'h7F, tag);
   endtask

   // Driver: one line bit, expected output pushed to the scoreboard
   task automatic send_bit(logic fs, logic d, logic e, string tag);
      @(negedge clk);
      bit_en = 1'b1; frame_sync = fs; tx_in = d;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      bit_en = 1'b0; frame_sync = 1'b0;
   endtask

   task automatic send_frame(logic e1, int seed, logic use_fs, int nbits,
                             int mid_slot, logic [7:0] mid_val, string tag);
      int len;
      logic cap_en;
      logic [7:0] cap_code;
      len = e1 ? 256 : 193;
      if (nbits > 0 && nbits < len) len = nbits;
      cap_en = 1'b0; cap_code = 8'h00;
      for (int i = 0; i < len; i++) begin
         logic d, e;
         int off, slot, b;
         d = 1'((((i * 29) + seed) >> 1) & 1);
         slot = -1; b = 0;
         if (!e1 && i == 0) begin
            e = d;
         end else begin
            off  = e1 ? i : i - 1;
            slot = off / 8;
            b    = off % 8;
            if (b == 0) begin
               cap_en   = m_en[slot];
               cap_code = m_tx[slot];
            end
            e = cap_en ? cap_code[7 - b] : d;
         end
         send_bit(use_fs && i == 0, d, e, tag);
         if (slot == mid_slot && b == 3) begin
            hwr(8'h7E, 8'(slot));
            hwr(8'h7F, mid_val);
         end
      end
   endtask

   // Monitor: compares tx_out after each strobed edge
   initial begin
      forever begin
         @(posedge clk);
         if (bit_en) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               chk("R10 unexpected strobe", 32'(tx_out), 32'hFFFF);
            end else begin
               logic e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, 32'(tx_out), 32'(e));
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) begin
         m_tx[i] = 8'h00;
         m_rx[i] = 8'h00;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      hrd(8'h7E, "R1 ptr reset");
      hrd(8'h7F, "R1 data reset");
      hrd(8'h80, "R1 en0 reset");
      hrd(8'h81, "R1 en1 reset");
      hrd(8'h82, "R1 en2 reset");
      hrd(8'h83, "R1 en3 reset");
      chk("R1 tx_out reset", 32'(tx_out), 32'h0);
      rd_entry(6'h3F, "R1 rx entry reset");

      // R2 pointer readback, no auto-increment
      hwr(8'h7E, 8'h05);
      hrd(8'h7E, "R2 ptr readback");
      hwr(8'h7F, 8'hA5);
      hrd(8'h7F, "R3 data read at ptr");
      hrd(8'h7F, "R2 second read same entry");
      hrd(8'h7E, "R2 ptr unchanged");

      // R3 single-entry writes in both banks
      hwr(8'h7E, 8'h00); hwr(8'h7F, 8'h81);
      hwr(8'h7E, 8'h1F); hwr(8'h7F, 8'h3C);
      hwr(8'h7E, 8'h20); hwr(8'h7F, 8'h77);
      hwr(8'h7E, 8'h3F); hwr(8'h7F, 8'hE1);
      rd_entry(6'h00, "R3 tx entry 00");
      rd_entry(6'h1F, "R3 tx entry 1F");
      rd_entry(6'h20, "R3 rx entry 20");
      rd_entry(6'h3F, "R3 rx entry 3F");
      rd_entry(6'h05, "R3 untouched entry 05");

      // R4/R5 transmit fill
      hwr(8'h7E, 8'h42);
      hrd(8'h7F, "R4 read during tx fill");
      hrd(8'h7E, "R2 ptr with tx flag");
      hwr(8'h7F, 8'hD2);
      rd_entry(6'h00, "R5 tx fill entry 00");
      rd_entry(6'h11, "R5 tx fill entry 11");
      rd_entry(6'h1F, "R5 tx fill entry 1F");
      rd_entry(6'h20, "R5 rx entry kept");

      // R4/R6 receive fill
      hwr(8'h7E, 8'hA1);
      hrd(8'h7F, "R4 read during rx fill");
      hwr(8'h7F, 8'h5A);
      rd_entry(6'h20, "R6 rx fill entry 20");
      rd_entry(6'h3F, "R6 rx fill entry 3F");
      rd_entry(6'h10, "R6 tx entry kept");

      // R7 enables and unmapped addresses
      hwr(8'h80, 8'h81);
      hwr(8'h81, 8'h5A);
      hwr(8'h82, 8'hF0);
      hwr(8'h83, 8'h80);
      hwr(8'h84, 8'hFF);
      hwr(8'h7D, 8'hFF);
      hrd(8'h80, "R7 en0");
      hrd(8'h81, "R7 en1");
      hrd(8'h82, "R7 en2");
      hrd(8'h83, "R7 en3");
      hrd(8'h84, "R7 unmapped 84");
      hrd(8'h7D, "R7 unmapped 7D");

      // Distinct code per transmit channel
      for (int c = 0; c < 32; c++) begin
         hwr(8'h7E, 8'(c));
         hwr(8'h7F, 8'((c * 37) + 8'h1B));
      end

      // R8 32-channel frames, R11 wrap without sync
      mode_e1 = 1'b1;
      send_frame(1'b1, 3, 1'b1, 0, -1, 8'h00, "R8 e1 frame");
      send_frame(1'b1, 11, 1'b0, 0, -1, 8'h00, "R11 e1 wrap no sync");

      // R12 mid-slot write on enabled channel 8 (slot 7)
      send_frame(1'b1, 5, 1'b1, 0, 7, 8'h0F, "R12 mid-slot write");
      send_frame(1'b1, 9, 1'b1, 0, -1, 8'h00, "R12 next frame new code");

      // R11 frame cut short by sync
      send_frame(1'b1, 21, 1'b1, 77, -1, 8'h00, "R11 partial frame");
      send_frame(1'b1, 4, 1'b1, 0, -1, 8'h00, "R11 restart on sync");

      // R9 24-channel mode, channels 25-32 enabled but unused
      hwr(8'h83, 8'hFF);
      hwr(8'h82, 8'hF5);
      mode_e1 = 1'b0;
      send_frame(1'b0, 7, 1'b1, 0, -1, 8'h00, "R9 t1 frame");
      send_frame(1'b0, 13, 1'b0, 0, -1, 8'h00, "R9 t1 wrap no sync");

      // R5 fill seen on the line
      hwr(8'h80, 8'hFF);
      hwr(8'h7E, 8'h40);
      hwr(8'h7F, 8'hC3);
      mode_e1 = 1'b1;
      send_frame(1'b1, 17, 1'b1, 0, -1, 8'h00, "R5 fill on line");

      wait (exp_q.size() == 0);
      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule